// File: doc/BRIEF.md
# Word-Serial Uneven-Width Adder

This block forms the plain integer sum of two operands held in banked memory. The first operand spans the full width, and the second spans only half of it. It is used once per exponentiation in the residue-recombination flow, where a full-size partial result has to be added to a half-size one. No modular reduction is applied.

Software or a sequencer loads the limb count of the wide operand and pulses `start`. The block then sweeps the limbs from the least significant upward, one limb per clock. Each cycle it issues a read of the wide operand. It reads the narrow operand only while the sweep is in the lower half of the limbs. In the upper half the narrow input is forced to zero, so only the carry moves on through the remaining limbs.

Each fetched limb pair passes through an operand register and then a carry-chained sum register, so the adder has two cycles of latency. Result limbs are written back in order. The carry out of the top limb is not written to the result bank. It is reported on a separate output.

Top module: `uadd_top`

## Requirements
- R1: While reset (`rstN` low, asynchronous, active low) is asserted and after its release with no start, the outputs `aRdEn`, `bRdEn`, `sumWrEn`, `done` and `carryOut` are 0.
- R2: A `start` sampled high while idle with `limbCount` = N (2 ≤ N ≤ MAX_LIMBS) produces N consecutive cycles with `aRdEn` high, beginning in the cycle after `start` is sampled. In those cycles `rdAddr` takes the values 0, 1, … N-1.
- R3: `bRdEn` is high only in the first N/2 of those cycles, at the same address as the wide operand. For limbs N/2 … N-1 the narrow operand counts as zero, whatever `bRdData` holds.
- R4: Result limb i equals the low LIMB_W bits of A[i] + B'[i] + c[i], where B'[i] is the narrow limb or zero, c[0] = 0 and c[i+1] is the carry out of limb i. It is written with `sumWrEn` at `sumWrAddr` = i exactly three cycles after the cycle in which limb i was read, in increasing address order.
- R5: `carryOut` takes the carry out of limb N-1 in the cycle `done` is high. It holds that value until the next operation completes.
- R6: `done` is high for exactly one cycle, the cycle right after the write of limb N-1.
- R7: A `start` sampled while an operation is in progress is ignored. The running sweep and its results are unaffected, and no second sweep follows.
- R8: A `start` sampled in the cycle `done` is high is accepted. The new operation begins with a carry-in of zero.
- R9: A `start` with `limbCount` below 2 is ignored, and no read is issued.
- R10: Memory reads are synchronous. Read data is taken from `aRdData`/`bRdData` in the cycle after the read was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an addition when idle |
| limbCount | input | CNT_W | Limb count of the wide operand (even) |
| rdAddr | output | ADDR_W | Limb address shared by both read ports |
| aRdEn | output | 1 | Read enable for the wide operand bank |
| aRdData | input | LIMB_W | Wide operand limb, one cycle after the read |
| bRdEn | output | 1 | Read enable for the narrow operand bank |
| bRdData | input | LIMB_W | Narrow operand limb, one cycle after the read |
| sumWrEn | output | 1 | Result write strobe |
| sumWrAddr | output | ADDR_W | Result limb address |
| sumWrData | output | LIMB_W | Result limb value |
| done | output | 1 | One-cycle completion pulse |
| carryOut | output | 1 | Carry out of the top limb |

## Verification
A wrong carry register would corrupt the next result limb written three cycles after its read, or `carryOut` at the `done` pulse for the top limb. Failing to mask the narrow operand shows as wrong upper result limbs, because the bench fills the upper narrow bank with non-zero data and the held read data stays non-zero. A sweep counter or state error shows within one cycle as a wrong `rdAddr`, a wrong `bRdEn`, or a misplaced or missing `done`.

// File: rtl/uadd_pkg.sv
package uadd_pkg;

  // Strobes the sweep control hands to the datapath with each issued limb.
  typedef struct packed {
    logic issue;   // a limb read is issued this cycle
    logic bZero;   // narrow operand is to be treated as zero for this limb
    logic first;   // lowest limb: carry-in forced to zero
    logic last;    // top limb of the sweep
  } uaddStrobe_t;

endpackage

// File: rtl/uadd_ctrl.sv
module uadd_ctrl
  import uadd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  limbCount,
  input  logic              lastWr,
  output uaddStrobe_t       strobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              aRdEn,
  output logic              bRdEn
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} ctrlState_t;

  ctrlState_t        state;
  logic [ADDR_W-1:0] idx;
  logic [CNT_W-1:0]  nReg;
  logic [CNT_W-1:0]  idxExt;
  logic [CNT_W-1:0]  halfCount;
  logic              inRun;
  logic              isLast;
  logic              inLow;
  logic              startOk;

  assign inRun     = (state == ST_RUN);
  assign idxExt    = CNT_W'(idx);
  assign halfCount = nReg >> 1;
  assign isLast    = (idxExt == nReg - CNT_W'(1));
  assign inLow     = (idxExt < halfCount);
  assign startOk   = start && (limbCount >= CNT_W'(2));

  always_comb begin
    strobe.issue = inRun;
    strobe.bZero = !inLow;
    strobe.first = (idx == '0);
    strobe.last  = isLast;
  end

  assign rdAddr = idx;
  assign aRdEn  = inRun;
  assign bRdEn  = inRun && inLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      nReg  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startOk) begin
            nReg  <= limbCount;
            idx   <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (isLast) state <= ST_DRAIN;
          else        idx   <= idx + ADDR_W'(1);
        end
        ST_DRAIN: begin
          if (lastWr) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uadd_add_stage.sv
module uadd_add_stage #(
  parameter int LIMB_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic [LIMB_W-1:0] opA,
  input  logic [LIMB_W-1:0] opB,
  output logic [LIMB_W-1:0] sum,
  output logic              carry
);

  localparam int SUM_W = LIMB_W + 1;

  logic             carryIn;
  logic [SUM_W-1:0] wide;

  assign carryIn = inFirst ? 1'b0 : carry;
  assign wide    = {1'b0, opA} + {1'b0, opB} + SUM_W'(carryIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sum   <= '0;
      carry <= 1'b0;
    end else if (inValid) begin
      sum   <= wide[LIMB_W-1:0];
      carry <= wide[LIMB_W];
    end
  end

endmodule

// File: rtl/uadd_dp.sv
module uadd_dp
  import uadd_pkg::*;
#(
  parameter int LIMB_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  uaddStrobe_t       strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [LIMB_W-1:0] aRdData,
  input  logic [LIMB_W-1:0] bRdData,
  output logic              sumWrEn,
  output logic [ADDR_W-1:0] sumWrAddr,
  output logic [LIMB_W-1:0] sumWrData,
  output logic              lastWr,
  output logic              done,
  output logic              carryOut
);

  // p1: read data in flight; p2: operands registered; p3: sum registered
  logic              p1V, p1Z, p1F, p1L;
  logic [ADDR_W-1:0] p1Addr;
  logic              p2V, p2F, p2L;
  logic [ADDR_W-1:0] p2Addr;
  logic [LIMB_W-1:0] opA, opB;
  logic              p3V, p3L;
  logic [ADDR_W-1:0] p3Addr;
  logic [LIMB_W-1:0] sumLimb;
  logic              chainCarry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p1V <= 1'b0; p1Z <= 1'b0; p1F <= 1'b0; p1L <= 1'b0; p1Addr <= '0;
    end else begin
      p1V    <= strobe.issue;
      p1Z    <= strobe.bZero;
      p1F    <= strobe.first;
      p1L    <= strobe.last;
      p1Addr <= rdAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p2V <= 1'b0; p2F <= 1'b0; p2L <= 1'b0; p2Addr <= '0;
      opA <= '0; opB <= '0;
    end else begin
      p2V    <= p1V;
      p2F    <= p1F;
      p2L    <= p1L;
      p2Addr <= p1Addr;
      if (p1V) begin
        opA <= aRdData;
        opB <= p1Z ? '0 : bRdData;
      end
    end
  end

  uadd_add_stage #(.LIMB_W(LIMB_W)) add_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (p2V),
    .inFirst (p2F),
    .opA     (opA),
    .opB     (opB),
    .sum     (sumLimb),
    .carry   (chainCarry)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p3V <= 1'b0; p3L <= 1'b0; p3Addr <= '0;
    end else begin
      p3V    <= p2V;
      p3L    <= p2V && p2L;
      p3Addr <= p2Addr;
    end
  end

  assign lastWr = p3V && p3L;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      carryOut <= 1'b0;
    end else begin
      done <= lastWr;
      if (lastWr) carryOut <= chainCarry;
    end
  end

  assign sumWrEn   = p3V;
  assign sumWrAddr = p3Addr;
  assign sumWrData = sumLimb;

endmodule

// File: rtl/uadd_top.sv
module uadd_top
  import uadd_pkg::*;
#(
  parameter int LIMB_W    = 16,
  parameter int MAX_LIMBS = 64,
  localparam int ADDR_W   = $clog2(MAX_LIMBS),
  localparam int CNT_W    = $clog2(MAX_LIMBS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  limbCount,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              aRdEn,
  input  logic [LIMB_W-1:0] aRdData,
  output logic              bRdEn,
  input  logic [LIMB_W-1:0] bRdData,
  output logic              sumWrEn,
  output logic [ADDR_W-1:0] sumWrAddr,
  output logic [LIMB_W-1:0] sumWrData,
  output logic              done,
  output logic              carryOut
);

  uaddStrobe_t strobe;
  logic        lastWr;

  uadd_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .limbCount (limbCount),
    .lastWr    (lastWr),
    .strobe    (strobe),
    .rdAddr    (rdAddr),
    .aRdEn     (aRdEn),
    .bRdEn     (bRdEn)
  );

  uadd_dp #(.LIMB_W(LIMB_W), .ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdAddr    (rdAddr),
    .aRdData   (aRdData),
    .bRdData   (bRdData),
    .sumWrEn   (sumWrEn),
    .sumWrAddr (sumWrAddr),
    .sumWrData (sumWrData),
    .lastWr    (lastWr),
    .done      (done),
    .carryOut  (carryOut)
  );

endmodule

// File: rtl/uadd_chk.sv
module uadd_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              aRdEn,
  input logic              bRdEn,
  input logic              sumWrEn,
  input logic [ADDR_W-1:0] sumWrAddr,
  input logic              done,
  input logic              carryOut
);

  // R4: every write lands three cycles after a wide-operand read
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rstN)
    sumWrEn |-> $past(aRdEn, 3));

  // R4: result addresses rise by one between consecutive writes
  p_wr_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sumWrEn && $past(sumWrEn)) |-> (sumWrAddr == $past(sumWrAddr) + ADDR_W'(1)));

  // R3: narrow reads only alongside a wide read
  p_b_with_a_r3: assert property (@(posedge clk) disable iff (!rstN)
    bRdEn |-> aRdEn);

  // R3: once the narrow port goes quiet inside a sweep it stays quiet
  p_b_stays_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (aRdEn && !bRdEn && $past(aRdEn) && (rdAddr != '0)) |=> !bRdEn);

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done follows a write
  p_done_after_wr_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(sumWrEn));

  // R5: carryOut moves only together with done
  p_carry_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(carryOut) |-> done);

  // R2: a read sweep never overlaps result draining of its own last limb with done
  p_no_rd_at_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !aRdEn);

endmodule

bind uadd_top uadd_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .rdAddr    (rdAddr),
  .aRdEn     (aRdEn),
  .bRdEn     (bRdEn),
  .sumWrEn   (sumWrEn),
  .sumWrAddr (sumWrAddr),
  .done      (done),
  .carryOut  (carryOut)
);

// File: tb/uadd_top_tb_top.sv
module uadd_top_tb_top;

  localparam int LIMB_W    = 16;
  localparam int MAX_LIMBS = 64;
  localparam int ADDR_W    = $clog2(MAX_LIMBS);
  localparam int CNT_W     = $clog2(MAX_LIMBS + 1);

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [LIMB_W-1:0] data;
    bit                last;
    bit                carry;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  limbCount = '0;
  logic [ADDR_W-1:0] rdAddr;
  logic              aRdEn, bRdEn;
  logic [LIMB_W-1:0] aRdData = '0;
  logic [LIMB_W-1:0] bRdData = '0;
  logic              sumWrEn;
  logic [ADDR_W-1:0] sumWrAddr;
  logic [LIMB_W-1:0] sumWrData;
  logic              done, carryOut;

  logic [LIMB_W-1:0] memA [MAX_LIMBS];
  logic [LIMB_W-1:0] memB [MAX_LIMBS];

  item_t expQ[$];
  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;
  bit    prevLast = 0;
  bit    prevCarry = 0;
  bit    lastCarry = 0;

  always #2 clk = ~clk;

  uadd_top #(.LIMB_W(LIMB_W), .MAX_LIMBS(MAX_LIMBS)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .limbCount(limbCount),
    .rdAddr(rdAddr), .aRdEn(aRdEn), .aRdData(aRdData),
    .bRdEn(bRdEn), .bRdData(bRdData),
    .sumWrEn(sumWrEn), .sumWrAddr(sumWrAddr), .sumWrData(sumWrData),
    .done(done), .carryOut(carryOut)
  );

  // synchronous memory models (R10)
  always @(posedge clk) begin
    if (aRdEn) aRdData <= memA[rdAddr];
    if (bRdEn) bRdData <= memB[rdAddr];
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected result limbs and checks done / carryOut
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (done || prevLast) check(done == prevLast, "R6 done timing", done, prevLast);
      if (done) check(carryOut == prevCarry, "R5 carryOut", carryOut, prevCarry);
      prevLast = 0;
      if (sumWrEn) begin
        if (expQ.size() == 0) begin
          check(0, "R4 unexpected write", sumWrAddr, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(sumWrAddr == it.addr, "R4 write addr", sumWrAddr, it.addr);
          check(sumWrData == it.data, "R4 write data", sumWrData, it.data);
          prevLast  = it.last;
          prevCarry = it.carry;
        end
      end
    end
  end

  task automatic fill(input int n, input int pattern);
    for (int i = 0; i < MAX_LIMBS; i++) begin
      case (pattern)
        0: begin memA[i] = LIMB_W'(i * 3 + 1); memB[i] = LIMB_W'(i + 5); end
        1: begin memA[i] = '1; memB[i] = (i == 0) ? LIMB_W'(1) : '0; end
        default: begin memA[i] = LIMB_W'($urandom); memB[i] = LIMB_W'($urandom); end
      endcase
      // narrow bank beyond its half holds garbage (R3)
      if (i >= n / 2) memB[i] = LIMB_W'(16'hA5C3 ^ i);
    end
  endtask

  // driver: computes expected results and runs one sweep; caller is at a negedge
  task automatic runOp(input int n, input bit poke);
    logic [LIMB_W:0] s;
    bit c;
    c = 0;
    for (int i = 0; i < n; i++) begin
      item_t it;
      s = {1'b0, memA[i]} + {1'b0, (i < n / 2) ? memB[i] : LIMB_W'(0)} + (LIMB_W + 1)'(c);
      c = s[LIMB_W];
      it.addr = ADDR_W'(i); it.data = s[LIMB_W-1:0];
      it.last = (i == n - 1); it.carry = c;
      expQ.push_back(it);
    end
    lastCarry = c;
    start = 1'b1;
    limbCount = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      check(aRdEn && rdAddr == ADDR_W'(i), "R2 read sweep", {aRdEn, rdAddr}, {1'b1, ADDR_W'(i)});
      check(bRdEn == (i < n / 2), "R3 narrow read enable", bRdEn, (i < n / 2));
      start = (poke && i == 2);
      limbCount = poke ? CNT_W'(2) : CNT_W'(n);
      @(negedge clk);
    end
    start = 1'b0;
    check(!aRdEn, "R2 sweep end", aRdEn, 0);
    while (!done) @(negedge clk);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check({aRdEn, bRdEn, sumWrEn, done, carryOut} == 5'b0, "R1 reset outputs",
          {aRdEn, bRdEn, sumWrEn, done, carryOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({aRdEn, bRdEn, sumWrEn, done, carryOut} == 5'b0, "R1 idle after reset",
          {aRdEn, bRdEn, sumWrEn, done, carryOut}, 0);

    // R9: counts below two are ignored
    for (int k = 0; k < 2; k++) begin
      start = 1'b1; limbCount = CNT_W'(k);
      @(negedge clk);
      start = 1'b0;
      repeat (4) begin
        check(!aRdEn && !sumWrEn, "R9 short count ignored", {aRdEn, sumWrEn}, 0);
        @(negedge clk);
      end
    end

    // R2 R3 R4: minimum size, simple values
    fill(2, 0); runOp(2, 0);
    // R4: counting pattern, eight limbs
    @(negedge clk); fill(8, 0); runOp(8, 0);
    // R5: carry ripples through the whole upper half
    @(negedge clk); fill(8, 1); runOp(8, 0);
    repeat (3) @(negedge clk);
    check(carryOut == 1'b1, "R5 carry held", carryOut, 1);
    // R7: start poked mid-sweep at the maximum size
    fill(MAX_LIMBS, 2); runOp(MAX_LIMBS, 1);
    // R8: back-to-back start in the done cycle, fresh carry chain
    fill(4, 2); runOp(4, 0);
    repeat (6) begin
      @(negedge clk);
      check(!aRdEn && !sumWrEn, "R7 no extra sweep", {aRdEn, sumWrEn}, 0);
    end
    check(carryOut == lastCarry, "R5 carry held after idle", carryOut, lastCarry);
    check(expQ.size() == 0, "R4 all results written", expQ.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule